// File: doc/BRIEF.md
# Generalized Bit-Reverse Permutation Unit

This block rearranges the bits of a 64-bit operand under the control of a small key. Output bit `i` takes the value of input bit `i XOR k`. The key comes from the low bits of a control word. Different keys give different permutations: swapping adjacent bits, reversing the bit order within nibbles or bytes, reversing the byte order, or reversing the whole word. With a key of all ones the word is reversed end to end. With a key of zero the operand passes through unchanged.

A narrow-mode input limits the operation to the lower 32 bits. In this mode the key is only 5 bits wide, only the lower half of the operand is read, and the upper half of the result is zero-filled. The datapath is a chain of log2(width) swap stages, one for each key bit. It is purely combinational, so the result is available in the same cycle as the operands. A valid flag follows the operation-select input directly.

Top module: `grev_perm_unit`

## Requirements
- R1: With `half_i`=0, `result_o[i]` equals `operand_i[i ^ k]` for every i in 0..63, where k = `ctrl_i[5:0]`.
- R2: With `half_i`=1, `result_o[i]` equals `operand_i[i ^ k]` for every i in 0..31, where k = `ctrl_i[4:0]`.
- R3: With `half_i`=1, `result_o[63:32]` is all zeros.
- R4: With `half_i`=1, `operand_i[63:32]` has no effect on `result_o`.
- R5: Control bits above the key field have no effect on `result_o`. These are `ctrl_i[63:6]` when `half_i`=0 and `ctrl_i[63:5]` when `half_i`=1.
- R6: `valid_o` equals `sel_i` in the same cycle.
- R7: A key of zero returns the operand unchanged. A key of all ones (63 when `half_i`=0, 31 when `half_i`=1) reverses the bit order of the active width.
- R8: The result depends only on the present inputs. It is due in the same cycle and has no dependence on earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 64 | Word to be permuted |
| ctrl_i | input | 64 | Control word; its low bits form the key |
| half_i | input | 1 | 1 selects 32-bit mode, 0 selects 64-bit mode |
| sel_i | input | 1 | Operation selected for this cycle |
| result_o | output | 64 | Permuted word |
| valid_o | output | 1 | High when the operation is selected |

## Verification
Every result of this block, including `valid_o`, is due in the same cycle that its inputs are applied, with no register in the path. The bench drives new inputs just after a rising edge and compares the outputs at the following falling edge. This leaves half a period for settling, and no comparison ever falls on the edge at which inputs change. Because the previous vector is always different, a design that held any state would show a mismatch. The sweep covers every key in both modes with several random operands per key. Each vector is also run with noise in the ignored control bits and, in narrow mode, in the ignored upper operand bits.

// File: rtl/grev_pkg.sv
package grev_pkg;

   // Width mode of the operation
   typedef enum logic {
      GREV_MODE_FULL = 1'b0,
      GREV_MODE_HALF = 1'b1
   } grev_mode_e;

   // Stage ordering variant of the butterfly
   typedef enum int {
      GREV_ORDER_ASCEND  = 0,
      GREV_ORDER_DESCEND = 1
   } grev_order_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int unsigned log2_exact(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/grev_swap_stage.sv
module grev_swap_stage #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned DIST   = 1
) (
   input  logic              en_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o
);

   if (DIST == 0 || DIST >= DATA_W) begin : g_bad_dist
      $error("grev_swap_stage: DIST must lie in 1..DATA_W-1");
   end

   // Each output bit picks its partner at distance DIST when enabled
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int unsigned PARTNER = b ^ DIST;
      assign dout_o[b] = en_i ? din_i[PARTNER] : din_i[b];
   end

endmodule

// File: rtl/grev_front.sv
module grev_front #(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned CTRL_REG_W = 64,
   parameter int unsigned SEL_W      = 6
) (
   input  logic [DATA_W-1:0]     operand_i,
   input  logic [CTRL_REG_W-1:0] ctrl_i,
   input  logic                  half_i,
   output logic [DATA_W-1:0]     data_o,
   output logic [SEL_W-1:0]      key_o
);
   import grev_pkg::*;

   localparam int unsigned HALF_W = DATA_W / 2;

   if (SEL_W < 2) begin : g_bad_sel
      $error("grev_front: SEL_W must be at least 2");
   end
   if (CTRL_REG_W < SEL_W) begin : g_bad_ctrl
      $error("grev_front: CTRL_REG_W must cover the key");
   end

   grev_mode_e mode;
   assign mode = grev_mode_e'(half_i);

   always_comb begin
      if (mode == GREV_MODE_HALF) begin
         data_o = {{HALF_W{1'b0}}, operand_i[HALF_W-1:0]};
         key_o  = {1'b0, ctrl_i[SEL_W-2:0]};
      end else begin
         data_o = operand_i;
         key_o  = ctrl_i[SEL_W-1:0];
      end
   end

   if (CTRL_REG_W > SEL_W) begin : g_ctrl_hi
      logic unused_ctrl_hi;
      assign unused_ctrl_hi = ^ctrl_i[CTRL_REG_W-1:SEL_W];
   end

   always_comb begin
      if (!$isunknown({half_i, operand_i})) begin
         // R4
         front_mask_chk: assert (!half_i || data_o[DATA_W-1:HALF_W] == '0)
            else $error("upper operand half leaked in narrow mode");
      end
      if (!$isunknown({half_i, ctrl_i[SEL_W-1:0]})) begin
         // R2
         key_width_chk: assert (!half_i || !key_o[SEL_W-1])
            else $error("top key bit active in narrow mode");
      end
   end

endmodule

// File: rtl/grev_butterfly.sv
module grev_butterfly #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned SEL_W  = 6,
   parameter int unsigned ORDER  = 0
) (
   input  logic [DATA_W-1:0] din_i,
   input  logic [SEL_W-1:0]  key_i,
   output logic [DATA_W-1:0] dout_o
);
   import grev_pkg::*;

   if ((1 << SEL_W) != DATA_W) begin : g_bad_width
      $error("grev_butterfly: DATA_W must equal 2**SEL_W");
   end
   if (ORDER != GREV_ORDER_ASCEND && ORDER != GREV_ORDER_DESCEND) begin : g_bad_order
      $error("grev_butterfly: unknown stage order");
   end

   logic [DATA_W-1:0] lvl [0:SEL_W];
   assign lvl[0] = din_i;

   for (genvar s = 0; s < SEL_W; s++) begin : g_stage
      localparam int unsigned KBIT = (ORDER == GREV_ORDER_ASCEND) ? s : (SEL_W - 1 - s);
      grev_swap_stage #(
         .DATA_W (DATA_W),
         .DIST   (1 << KBIT)
      ) stage_i (
         .en_i   (key_i[KBIT]),
         .din_i  (lvl[s]),
         .dout_o (lvl[s+1])
      );

      always_comb begin
         if (!$isunknown({key_i, din_i})) begin
            // R1
            stage_weight_chk: assert ($countones(lvl[s+1]) == $countones(lvl[s]))
               else $error("stage %0d changed the number of set bits", s);
         end
      end
   end

   assign dout_o = lvl[SEL_W];

endmodule

// File: rtl/grev_perm_unit.sv
module grev_perm_unit #(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned CTRL_REG_W = 64,
   parameter int unsigned ORDER      = 0
) (
   input  logic [DATA_W-1:0]     operand_i,
   input  logic [CTRL_REG_W-1:0] ctrl_i,
   input  logic                  half_i,
   input  logic                  sel_i,
   output logic [DATA_W-1:0]     result_o,
   output logic                  valid_o
);
   import grev_pkg::*;

   localparam int unsigned SEL_W  = log2_exact(DATA_W);
   localparam int unsigned HALF_W = DATA_W / 2;

   if (!is_pow2(DATA_W) || DATA_W < 4) begin : g_bad_data
      $error("grev_perm_unit: DATA_W must be a power of two, at least 4");
   end
   if (CTRL_REG_W < SEL_W) begin : g_bad_ctrl
      $error("grev_perm_unit: CTRL_REG_W too narrow for the key");
   end

   logic [DATA_W-1:0] front_data;
   logic [SEL_W-1:0]  front_key;

   grev_front #(
      .DATA_W     (DATA_W),
      .CTRL_REG_W (CTRL_REG_W),
      .SEL_W      (SEL_W)
   ) front_i (
      .operand_i (operand_i),
      .ctrl_i    (ctrl_i),
      .half_i    (half_i),
      .data_o    (front_data),
      .key_o     (front_key)
   );

   grev_butterfly #(
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W),
      .ORDER  (ORDER)
   ) net_i (
      .din_i  (front_data),
      .key_i  (front_key),
      .dout_o (result_o)
   );

   assign valid_o = sel_i;

   // Direct index-XOR reference, independent of the staged network
   logic [DATA_W-1:0] ref_perm;
   int unsigned       ref_key;

   always_comb begin
      ref_key = half_i ? int'(ctrl_i[SEL_W-2:0]) : int'(ctrl_i[SEL_W-1:0]);
      ref_perm = '0;
      for (int unsigned i = 0; i < DATA_W; i++) begin
         if (!(half_i && i >= HALF_W)) ref_perm[i] = operand_i[i ^ ref_key];
      end
   end

   always_comb begin
      if (!$isunknown({operand_i, ctrl_i[SEL_W-1:0], half_i})) begin
         // R1 R2
         perm_ref_chk: assert (result_o == ref_perm)
            else $error("staged result differs from index-XOR reference");
         // R3
         upper_zero_chk: assert (!half_i || result_o[DATA_W-1:HALF_W] == '0)
            else $error("upper result half not zero in narrow mode");
      end
   end

endmodule

// File: tb/grev_perm_unit_tb_top.sv
module grev_perm_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] operand = '0;
   logic [63:0] ctrl = '0;
   logic        half = 1'b0;
   logic        sel = 1'b0;
   logic [63:0] result;
   logic        valid;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   grev_perm_unit dut_i (
      .operand_i (operand),
      .ctrl_i    (ctrl),
      .half_i    (half),
      .sel_i     (sel),
      .result_o  (result),
      .valid_o   (valid)
   );

   function automatic logic [63:0] model(logic [63:0] d, logic [63:0] c, logic h);
      logic [63:0] r;
      int unsigned k;
      k = h ? int'(c[4:0]) : int'(c[5:0]);
      r = '0;
      for (int unsigned i = 0; i < 64; i++) begin
         if (!(h && i >= 32)) r[i] = d[i ^ k];
      end
      return r;
   endfunction

   function automatic logic [63:0] rand64();
      return {$urandom, $urandom};
   endfunction

   task automatic check64(string rid, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", rid, act, exp);
      end
   endtask

   // Drive just after a rising edge, compare at the falling edge
   task automatic apply(logic [63:0] d, logic [63:0] c, logic h, logic s);
      @(posedge clk);
      #1;
      operand = d;
      ctrl    = c;
      half    = h;
      sel     = s;
      @(negedge clk);
   endtask

   initial begin
      logic [63:0] d;
      logic [63:0] noise;
      logic [63:0] rev;

      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: nothing selected, valid low
      check64("R6 reset", {63'd0, valid}, 64'd0);
      rst_n = 1'b1;

      // R1 R5: full sweep of keys in 64-bit mode
      for (int k = 0; k < 64; k++) begin
         for (int r = 0; r < 3; r++) begin
            d = rand64();
            apply(d, 64'(k), 1'b0, 1'b1);
            check64("R1", result, model(d, 64'(k), 1'b0));
            noise = rand64() & ~64'h3f;
            apply(d, noise | 64'(k), 1'b0, 1'b1);
            check64("R5", result, model(d, 64'(k), 1'b0));
         end
      end

      // R2 R3 R4 R5: full sweep of keys in 32-bit mode
      for (int k = 0; k < 32; k++) begin
         for (int r = 0; r < 3; r++) begin
            d = rand64();
            apply({32'd0, d[31:0]}, 64'(k), 1'b1, 1'b1);
            check64("R2", result, model(d, 64'(k), 1'b1));
            check64("R3", {32'd0, result[63:32]}, 64'd0);
            apply(d, 64'(k), 1'b1, 1'b1);
            check64("R4", result, model({32'd0, d[31:0]}, 64'(k), 1'b1));
            noise = rand64() & ~64'h1f;
            apply(d, noise | 64'(k), 1'b1, 1'b1);
            check64("R5", result, model(d, 64'(k), 1'b1));
         end
      end

      // R7: identity and full reversal in both modes
      d = rand64();
      apply(d, 64'd0, 1'b0, 1'b1);
      check64("R7 identity64", result, d);
      apply(d, 64'd0, 1'b1, 1'b1);
      check64("R7 identity32", result, {32'd0, d[31:0]});
      rev = '0;
      for (int i = 0; i < 64; i++) rev[i] = d[63 - i];
      apply(d, 64'd63, 1'b0, 1'b1);
      check64("R7 reverse64", result, rev);
      rev = '0;
      for (int i = 0; i < 32; i++) rev[i] = d[31 - i];
      apply(d, 64'd31, 1'b1, 1'b1);
      check64("R7 reverse32", result, rev);

      // R6: valid tracks select in the same cycle
      apply(d, 64'd5, 1'b0, 1'b0);
      check64("R6 deselect", {63'd0, valid}, 64'd0);
      apply(d, 64'd5, 1'b0, 1'b1);
      check64("R6 select", {63'd0, valid}, 64'd1);

      // R8: alternate patterns; no memory of the previous vector
      for (int r = 0; r < 40; r++) begin
         logic [63:0] c;
         logic h;
         d = rand64();
         c = rand64();
         h = r[0];
         apply(d, c, h, 1'b1);
         check64("R8", result, model(d, c, h));
      end

      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule